// File: doc/BRIEF.md
# Floating-Point Status Register Updater

This block owns a 32-bit floating-point status and control word and rewrites it once for each completed floating-point operation. An operation arrives as a one-cycle strobe that carries its exception events: a set of invalid-operation causes, overflow, underflow, divide-by-zero, inexact, the fraction-rounded and fraction-inexact flags, and a result-class code. On that edge the block merges the events into the word. The merge rule differs per bit: some bits are sticky, some follow the event, and some are replaced outright. In the same edge it recomputes the invalid summary and the enabled-exception summary.

When the operation requests a record, the four uppermost status bits of the new word are copied to a condition-field output, and a one-cycle update strobe marks the copy. When either floating-point exception mode bit from the machine state is set and the new enabled-exception summary is set, a registered interrupt request is raised. The request holds until it is acknowledged. A direct write port loads the whole word. This port is the only way, besides reset, to clear sticky bits.

Top module: `fpstat_unit`

Word layout, bit 0 is the least significant: [31] sticky exception summary, [30] enabled-exception summary, [29] invalid summary, [28] overflow, [27] underflow, [26] divide-by-zero, [25] inexact, [24:16] invalid causes, [15] fraction rounded, [14] fraction inexact, [13:9] result class (condition code is [12:9]), [8] invalid enable, [7] overflow enable, [6] underflow enable, [5] divide-by-zero enable, [4] inexact enable, [3:0] control bits kept unchanged by operations.

## Requirements
- R1: While `rst` is high at a clock edge, `fpsr`, `cr1`, `cr1_upd` and `irq_req` all become zero.
- R2: After an operation, bit 29 equals the OR of cause bits [24:16].
- R3: After an operation, bit 30 is 1 exactly when at least one of these pairs has both bits set in the new word: 29&8, 28&7, 27&6, 26&5, 25&4.
- R4: Bits 28, 27 and 26 take the values of `ovf_in`, `unf_in` and `zdiv_in` on each operation. An asserted event also sets bit 31, and a deasserted event leaves bit 31 alone.
- R5: An operation with `inx_in` high sets bits 25 and 31. With `inx_in` low, bit 25 keeps its value.
- R6: An operation ORs `inv_cause` into bits [24:16], and sets bit 31 if any cause bit is high.
- R7: Bits 15 and 14 take `frnd_in` and `finx_in` on each operation, set or cleared, and never change bit 31.
- R8: Bits [13:9] are replaced by `rclass_in` on each operation. Bits [8:0] are not changed by operations.
- R9: An operation with `record_in` high loads `cr1` with the new bits [31:28] and pulses `cr1_upd` for one cycle. Without `record_in`, `cr1` holds and `cr1_upd` is low.
- R10: `irq_req` rises on the edge of an operation whose new bit 30 is 1 while `fe_mode` is nonzero. It then holds until an `irq_ack` edge with no new raise. A raise wins over a simultaneous acknowledge.
- R11: `wr_en` loads `wr_data` verbatim into the word, takes priority over a simultaneous operation, and neither updates `cr1` nor raises `irq_req`.
- R12: With neither `op_valid` nor `wr_en` high, the word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe: an operation completed |
| inv_cause | input | 9 | Invalid-operation cause events |
| ovf_in | input | 1 | Overflow event |
| unf_in | input | 1 | Underflow event |
| zdiv_in | input | 1 | Divide-by-zero event |
| inx_in | input | 1 | Inexact event |
| frnd_in | input | 1 | Fraction-rounded condition |
| finx_in | input | 1 | Fraction-inexact condition |
| rclass_in | input | 5 | Result-class code |
| record_in | input | 1 | Copy status to condition field |
| fe_mode | input | 2 | Floating-point exception mode bits from machine state |
| irq_ack | input | 1 | Interrupt acknowledge |
| wr_en | input | 1 | Direct word write |
| wr_data | input | 32 | Direct write value |
| fpsr | output | 32 | Status and control word |
| cr1 | output | 4 | Condition field copy |
| cr1_upd | output | 1 | Pulse: `cr1` was loaded |
| irq_req | output | 1 | Enabled-exception interrupt request |

## Verification
A wrong merge rule, such as a sticky bit that clears or a following bit that sticks, appears on `fpsr` at the edge that ends the operation. It is caught at the next half-cycle sample. A summary computed from the old word instead of the new one shows the same cycle on bits 29 and 30. Through them it also shows on `irq_req` and `cr1`, so wrong interrupt gating or a wrong copy is visible one edge after the strobe. A request dropped before its acknowledge, or held after it, is visible on the first cycle it differs.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int REG_W   = 32;
  localparam int CAUSE_W = 9;
  localparam int CLASS_W = 5;
  localparam int CRF_W   = 4;

  localparam int B_XSUM  = 31;
  localparam int B_ESUM  = 30;
  localparam int B_ISUM  = 29;
  localparam int B_OVF   = 28;
  localparam int B_UNF   = 27;
  localparam int B_ZDV   = 26;
  localparam int B_INX   = 25;
  localparam int CAUSE_LO = 16;
  localparam int B_FRND  = 15;
  localparam int B_FINX  = 14;
  localparam int CLASS_LO = 9;
  localparam int B_EN_INV = 8;
  localparam int B_EN_OVF = 7;
  localparam int B_EN_UNF = 6;
  localparam int B_EN_ZDV = 5;
  localparam int B_EN_INX = 4;

  typedef struct packed {
    logic [CAUSE_W-1:0] inv;
    logic               ovf;
    logic               unf;
    logic               zdv;
    logic               inx;
    logic               frnd;
    logic               finx;
    logic [CLASS_W-1:0] rclass;
  } fp_evt_t;
endpackage

// File: rtl/fpstat_merge.sv
module fpstat_merge
  import fpstat_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  fp_evt_t          evt,
  output logic [REG_W-1:0] nxt
);
  localparam int CAUSE_HI = CAUSE_LO + CAUSE_W - 1;
  localparam int CLASS_HI = CLASS_LO + CLASS_W - 1;

  logic [CAUSE_W-1:0] causes;
  logic               inx_bit;
  logic               raised;
  logic               isum;

  always_comb begin
    causes  = cur[CAUSE_HI:CAUSE_LO] | evt.inv;
    inx_bit = cur[B_INX] | evt.inx;
    raised  = evt.ovf | evt.unf | evt.zdv | evt.inx | (|evt.inv);
    isum    = |causes;

    nxt                      = cur;
    nxt[CAUSE_HI:CAUSE_LO]   = causes;
    nxt[B_OVF]               = evt.ovf;
    nxt[B_UNF]               = evt.unf;
    nxt[B_ZDV]               = evt.zdv;
    nxt[B_INX]               = inx_bit;
    nxt[B_XSUM]              = cur[B_XSUM] | raised;
    nxt[B_FRND]              = evt.frnd;
    nxt[B_FINX]              = evt.finx;
    nxt[CLASS_HI:CLASS_LO]   = evt.rclass;
    nxt[B_ISUM]              = isum;
    nxt[B_ESUM]              = (isum     & cur[B_EN_INV]) |
                               (evt.ovf  & cur[B_EN_OVF]) |
                               (evt.unf  & cur[B_EN_UNF]) |
                               (evt.zdv  & cur[B_EN_ZDV]) |
                               (inx_bit  & cur[B_EN_INX]);
  end
endmodule

// File: rtl/fpstat_irq.sv
module fpstat_irq (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)        req <= 1'b0;
    else if (raise) req <= 1'b1;
    else if (ack)   req <= 1'b0;
  end

  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
  assert_raise_wins_R10: assert property (@(posedge clk) disable iff (rst)
    raise |=> req);
endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit
  import fpstat_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [CAUSE_W-1:0] inv_cause,
  input  logic               ovf_in,
  input  logic               unf_in,
  input  logic               zdiv_in,
  input  logic               inx_in,
  input  logic               frnd_in,
  input  logic               finx_in,
  input  logic [CLASS_W-1:0] rclass_in,
  input  logic               record_in,
  input  logic [1:0]         fe_mode,
  input  logic               irq_ack,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   fpsr,
  output logic [CRF_W-1:0]   cr1,
  output logic               cr1_upd,
  output logic               irq_req
);
  localparam int CAUSE_HI = CAUSE_LO + CAUSE_W - 1;

  fp_evt_t          evt;
  logic [REG_W-1:0] merged;
  logic             do_op;
  logic             raise;

  assign evt = '{inv: inv_cause, ovf: ovf_in, unf: unf_in, zdv: zdiv_in,
                 inx: inx_in, frnd: frnd_in, finx: finx_in, rclass: rclass_in};
  assign do_op = op_valid & ~wr_en;
  assign raise = do_op & (|fe_mode) & merged[B_ESUM];

  fpstat_merge u_merge (
    .cur (fpsr),
    .evt (evt),
    .nxt (merged)
  );

  fpstat_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .raise (raise),
    .ack   (irq_ack),
    .req   (irq_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fpsr    <= '0;
      cr1     <= '0;
      cr1_upd <= 1'b0;
    end else begin
      cr1_upd <= 1'b0;
      if (wr_en) begin
        fpsr <= wr_data;
      end else if (op_valid) begin
        fpsr <= merged;
        if (record_in) begin
          cr1     <= merged[REG_W-1 -: CRF_W];
          cr1_upd <= 1'b1;
        end
      end
    end
  end

  assert_isum_R2: assert property (@(posedge clk) disable iff (rst)
    do_op |=> fpsr[B_ISUM] == (|fpsr[CAUSE_HI:CAUSE_LO]));
  assert_ovf_sets_xsum_R4: assert property (@(posedge clk) disable iff (rst)
    (do_op && ovf_in) |=> (fpsr[B_OVF] && fpsr[B_XSUM]));
  assert_inx_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (do_op && !inx_in) |=> fpsr[B_INX] == $past(fpsr[B_INX]));
  assert_cr_copy_R9: assert property (@(posedge clk) disable iff (rst)
    (do_op && record_in) |=> (cr1_upd && cr1 == fpsr[REG_W-1 -: CRF_W]));
  assert_write_no_irq_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !irq_req) |=> !irq_req);
  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !wr_en) |=> $stable(fpsr));
endmodule

// File: tb/fpstat_unit_test.sv
module fpstat_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [8:0]  inv_cause = '0;
  logic        ovf_in = 0, unf_in = 0, zdiv_in = 0, inx_in = 0;
  logic        frnd_in = 0, finx_in = 0;
  logic [4:0]  rclass_in = '0;
  logic        record_in = 0;
  logic [1:0]  fe_mode = '0;
  logic        irq_ack = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] fpsr;
  logic [3:0]  cr1;
  logic        cr1_upd;
  logic        irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_reg = '0;
  logic [3:0]  m_cr  = '0;
  logic        m_upd = 0;
  logic        m_irq = 0;

  always #2 clk = ~clk;

  fpstat_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .inv_cause(inv_cause),
    .ovf_in(ovf_in), .unf_in(unf_in), .zdiv_in(zdiv_in), .inx_in(inx_in),
    .frnd_in(frnd_in), .finx_in(finx_in), .rclass_in(rclass_in),
    .record_in(record_in), .fe_mode(fe_mode), .irq_ack(irq_ack),
    .wr_en(wr_en), .wr_data(wr_data), .fpsr(fpsr), .cr1(cr1),
    .cr1_upd(cr1_upd), .irq_req(irq_req)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, applied after each rising edge.
  task automatic model_edge();
    logic [31:0] e;
    logic any;
    if (rst) begin
      m_reg = '0; m_cr = '0; m_upd = 0; m_irq = 0;
      return;
    end
    m_upd = 0;
    if (wr_en) begin
      m_reg = wr_data;
      if (irq_ack) m_irq = 0;
      return;
    end
    if (!op_valid) begin
      if (irq_ack) m_irq = 0;
      return;
    end
    e = m_reg;
    any = ovf_in || unf_in || zdiv_in || inx_in || (inv_cause != 0);
    e[28] = ovf_in; e[27] = unf_in; e[26] = zdiv_in;
    if (inx_in) e[25] = 1;
    e[24:16] = e[24:16] | inv_cause;
    if (any) e[31] = 1;
    e[15] = frnd_in; e[14] = finx_in;
    e[13:9] = rclass_in;
    e[29] = (e[24:16] != 0);
    e[30] = (e[29] && e[8]) || (e[28] && e[7]) || (e[27] && e[6]) ||
            (e[26] && e[5]) || (e[25] && e[4]);
    m_reg = e;
    if (record_in) begin m_cr = e[31:28]; m_upd = 1; end
    if (fe_mode != 0 && e[30]) m_irq = 1;
    else if (irq_ack) m_irq = 0;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(tag, "fpsr", fpsr, m_reg);
    cmp(tag, "cr1", {28'd0, cr1}, {28'd0, m_cr});
    cmp(tag, "cr1_upd", {31'd0, cr1_upd}, {31'd0, m_upd});
    cmp(tag, "irq_req", {31'd0, irq_req}, {31'd0, m_irq});
    op_valid = 0; wr_en = 0; irq_ack = 0; record_in = 0;
    inv_cause = '0; ovf_in = 0; unf_in = 0; zdiv_in = 0; inx_in = 0;
    frnd_in = 0; finx_in = 0; rclass_in = '0;
  endtask

  task automatic op(input logic [8:0] c, input logic o, input logic u, input logic z,
                    input logic x, input logic fr, input logic fi, input logic [4:0] rc,
                    input logic rec, input string tag);
    op_valid = 1; inv_cause = c; ovf_in = o; unf_in = u; zdiv_in = z; inx_in = x;
    frnd_in = fr; finx_in = fi; rclass_in = rc; record_in = rec;
    step(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    // R12 idle with no stimulus
    step("R12");
    // R11 write enables only, control bits 3:0 set
    wr_en = 1; wr_data = 32'h0000_000A; step("R11");
    // R4 overflow with no enables: sets ovf and xsum, no esum
    op(9'h0, 1, 0, 0, 0, 0, 0, 5'h03, 1, "R4");
    // R4 deassert: clears ovf, xsum stays
    op(9'h0, 0, 0, 0, 0, 0, 0, 5'h04, 0, "R4");
    // R5 inexact set then not asserted: stays
    op(9'h0, 0, 0, 0, 1, 0, 0, 5'h05, 0, "R5");
    op(9'h0, 0, 0, 0, 0, 0, 0, 5'h06, 0, "R5");
    // R7 fraction flags follow, xsum untouched after reset of word
    wr_en = 1; wr_data = 32'h0000_0000; step("R11");
    op(9'h0, 0, 0, 0, 0, 1, 1, 5'h1F, 1, "R7");
    op(9'h0, 0, 0, 0, 0, 0, 1, 5'h00, 1, "R7 R8");
    // R6 R2 causes OR in
    op(9'h005, 0, 0, 0, 0, 0, 0, 5'h11, 0, "R6 R2");
    op(9'h100, 0, 0, 0, 0, 0, 0, 5'h12, 1, "R6 R2 R9");
    // R3 enable overflow; no mode: esum set, no irq
    wr_en = 1; wr_data = 32'h0000_0080; step("R11");
    op(9'h0, 1, 0, 0, 0, 0, 0, 5'h01, 1, "R3 R9");
    op(9'h0, 0, 1, 0, 0, 0, 0, 5'h01, 0, "R3");
    // R10 mode on, underflow enabled
    wr_en = 1; wr_data = 32'h0000_0040; step("R11");
    fe_mode = 2'b01;
    op(9'h0, 0, 1, 0, 0, 0, 0, 5'h02, 0, "R10");
    step("R10"); step("R10");
    irq_ack = 1; step("R10");
    // R10 raise wins over ack
    fe_mode = 2'b10; irq_ack = 1;
    op(9'h0, 0, 1, 0, 0, 0, 0, 5'h02, 1, "R10");
    irq_ack = 1; step("R10");
    // R10 op without enabled event: no raise
    op(9'h0, 0, 0, 0, 0, 0, 0, 5'h02, 0, "R10 R3");
    // R3 invalid enable with cause; inexact enable
    wr_en = 1; wr_data = 32'h0000_0110; step("R11");
    op(9'h020, 0, 0, 0, 0, 0, 0, 5'h07, 1, "R3 R6");
    irq_ack = 1; step("R10");
    op(9'h0, 0, 0, 1, 1, 0, 0, 5'h08, 1, "R3 R5 R4");
    // R11 write beats op, no cr1 update
    irq_ack = 1; step("R10");
    wr_en = 1; wr_data = 32'h1234_5670;
    op(9'h1FF, 1, 1, 1, 1, 1, 1, 5'h1F, 1, "R11");
    step("R12"); step("R12");
    // R1 reset mid-run
    rst = 1; step("R1"); rst = 0;
    step("R1");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule